// File: doc/BRIEF.md
# Dual-Source Clock Controller

This block manages the two clock sources of a small low-power system and produces its system clock. One source is fast and on-chip. It is modelled as a divider of a reference that stands for 2 MHz, and it can run at the full, half or quarter reference rate. The other source is a 32.768 kHz sub-clock for timers and low-power periods. Each source has an enable field and a programmable stabilization wait. A source does not pass any clock and does not report ready until it has run for the chosen number of its own cycles.

The fast source is forced off while the sleep input is high, and it then restarts its wait when sleep ends. The sub-clock keeps running through sleep. The system clock comes from one of the two sources through a glitch-free switch. A switch request is accepted only when the target source reports ready. A divided copy of the system clock is also available as a clock-out pin.

The control inputs are register fields held by logic outside this block, so their reset values are applied there. In particular, the fast enable is 1 and the selection is the fast source out of reset.

Top module: `dual_clk_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, both ready flags are 0, the selection flag is 0 (fast source), and neither the system clock nor the clock-out toggles.
- R2: With the fast enable at 1, the fast ready flag rises only after the fast source has run for a number of its own cycles set by the wait code: code 0 gives 128, code 1 gives 64, code 2 gives 32 and code 3 gives 16. The flag rises no more than 6 reference cycles after that count is reached.
- R3: After reset, the system clock follows the fast source as soon as the fast source becomes ready, with no switch request needed.
- R4: When the fast enable goes to 0, the fast ready flag falls and the fast source stops driving the system clock within 8 reference cycles.
- R5: While sleep is 1, the fast source is stopped whatever its enable says. When sleep returns to 0, the full stabilization wait is counted again before ready rises.
- R6: The fast rate code selects the reference divided by 1 (code 0), by 2 (code 1) or by 4 (code 2). The reserved code 3 behaves like code 0.
- R7: The sub-clock has its own enable and wait code, with the same code-to-count mapping as the fast source, counted in sub-clock cycles. Sleep does not stop it and does not clear its ready flag.
- R8: A request to move the system clock to a source whose ready flag is 0 is ignored: the selection flag and the system clock stay as they were.
- R9: A request to move to a ready source updates the selection flag, and the system clock then follows that source. During the change, no high or low pulse is shorter than half a fast reference period.
- R10: With the clock-out enabled, the clock-out is the system clock divided by 1, 2, 4 or 8 for codes 0, 1, 2 and 3.
- R11: With the clock-out enable at 0, the clock-out is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_ref_i | input | 1 | Reference for the fast source; also clocks the selection logic |
| slow_ref_i | input | 1 | 32.768 kHz sub-clock reference |
| rst_n | input | 1 | Asynchronous reset, active low |
| fast_en_i | input | 1 | Fast source enable |
| fast_rate_i | input | 2 | Fast source rate code |
| fast_wait_i | input | 2 | Fast source stabilization wait code |
| slow_en_i | input | 1 | Sub-clock enable |
| slow_wait_i | input | 2 | Sub-clock stabilization wait code |
| sleep_i | input | 1 | Sleep request; stops the fast source |
| sys_sel_slow_i | input | 1 | Requested system clock source, 1 selects the sub-clock |
| cko_en_i | input | 1 | Clock-out enable |
| cko_div_i | input | 2 | Clock-out divide code |
| sys_clk_o | output | 1 | System clock |
| sys_on_slow_o | output | 1 | Accepted selection, 1 when the sub-clock is selected |
| fast_rdy_o | output | 1 | Fast source ready |
| slow_rdy_o | output | 1 | Sub-clock ready |
| cko_o | output | 1 | Divided clock-out |

## Verification
The bench uses the default parameters: a longest wait of 128 cycles for both sources, two synchronizer stages, and a three-bit clock-out counter. With these values every wait code, from 128 cycles down to 16, finishes within a few hundred reference cycles, so each code's ready latency is measured against its own window. The sub-clock reference is made much slower than the fast reference and is not a multiple of it. This exercises the switch's handover between unrelated clocks, and the edge-count windows clearly tell the two sources apart.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    typedef enum logic [1:0] {
        RATE_FULL    = 2'd0,
        RATE_HALF    = 2'd1,
        RATE_QUARTER = 2'd2,
        RATE_SPARE   = 2'd3
    } rate_e;

    // The spare rate code runs at full rate.
    function automatic logic [1:0] rate_norm(input logic [1:0] code);
        return (code == RATE_SPARE) ? RATE_FULL : code;
    endfunction

endpackage

// File: rtl/dclk_source.sv
module dclk_source
    import dclk_pkg::*;
#(
    parameter int WAIT_LONG     = 128,
    parameter bit STOP_IN_SLEEP = 1'b1,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       sleep_i,
    input  logic [1:0] rate_i,
    input  logic [1:0] wait_i,
    output logic       raw_clk_o,
    output logic       src_clk_o,
    output logic       ready_o
);
    localparam int CNT_W = $clog2(WAIT_LONG + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] run_sync;
        logic [1:0]             div;
        logic [CNT_W-1:0]       cnt;
        logic                   ready;
    } src_state_t;

    src_state_t       st_d, st_q;
    logic             run_req, run_s, tick, raw_div, gate_q;
    logic [1:0]       code;
    logic [CNT_W-1:0] limit, cnt_inc;

    always_comb begin
        code    = rate_norm(rate_i);
        run_req = en_i & ~(STOP_IN_SLEEP & sleep_i);
        run_s   = st_q.run_sync[SYNC_STAGES-1];
        limit   = CNT_W'(WAIT_LONG >> wait_i);
        cnt_inc = st_q.cnt + CNT_W'(1);
        case (code)
            RATE_HALF: begin
                tick    = st_q.div[0];
                raw_div = st_q.div[0];
            end
            RATE_QUARTER: begin
                tick    = &st_q.div;
                raw_div = st_q.div[1];
            end
            default: begin
                tick    = 1'b1;
                raw_div = 1'b0;
            end
        endcase

        st_d          = st_q;
        st_d.run_sync = {st_q.run_sync[SYNC_STAGES-2:0], run_req};
        st_d.div      = st_q.div + 2'd1;
        if (!run_s) begin
            st_d.cnt   = '0;
            st_d.ready = 1'b0;
        end else if (!st_q.ready && tick) begin
            st_d.cnt = cnt_inc;
            if (cnt_inc >= limit) begin
                st_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The gate only moves while the divided clock is low, so no pulse is cut.
    always_ff @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if ((code == RATE_FULL) || !raw_div) begin
            gate_q <= st_q.ready;
        end
    end

    assign raw_clk_o = (code == RATE_FULL) ? ref_clk : raw_div;
    assign src_clk_o = raw_clk_o & gate_q;
    assign ready_o   = st_q.ready;

    // R4 / R5: losing the run request clears ready on the next edge.
    p_ready_clear_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !run_s |=> !st_q.ready);

    // R2: once ready, the flag stays up while the source keeps running.
    p_ready_hold_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (st_q.ready && run_s) |=> st_q.ready);

endmodule

// File: rtl/dclk_glitchfree.sv
module dclk_glitchfree #(
    parameter int SYNC_STAGES = 2
) (
    input  logic rst_n,
    input  logic a_raw_i,
    input  logic a_clk_i,
    input  logic b_raw_i,
    input  logic b_clk_i,
    input  logic sel_b_i,
    output logic clk_o
);
    logic [SYNC_STAGES-1:0] a_sync_d, a_sync_q, b_sync_d, b_sync_q;
    logic                   a_en_q, b_en_q;

    always_comb begin
        a_sync_d = {a_sync_q[SYNC_STAGES-2:0], ~sel_b_i & ~b_en_q};
        b_sync_d = {b_sync_q[SYNC_STAGES-2:0], sel_b_i & ~a_en_q};
    end

    always_ff @(posedge a_raw_i or negedge rst_n) begin
        if (!rst_n) begin
            a_sync_q <= '1;
        end else begin
            a_sync_q <= a_sync_d;
        end
    end

    always_ff @(negedge a_raw_i or negedge rst_n) begin
        if (!rst_n) begin
            a_en_q <= 1'b1;
        end else begin
            a_en_q <= a_sync_q[SYNC_STAGES-1];
        end
    end

    always_ff @(posedge b_raw_i or negedge rst_n) begin
        if (!rst_n) begin
            b_sync_q <= '0;
        end else begin
            b_sync_q <= b_sync_d;
        end
    end

    always_ff @(negedge b_raw_i or negedge rst_n) begin
        if (!rst_n) begin
            b_en_q <= 1'b0;
        end else begin
            b_en_q <= b_sync_q[SYNC_STAGES-1];
        end
    end

    assign clk_o = (a_clk_i & a_en_q) | (b_clk_i & b_en_q);

    // R9: the two source paths are never open together.
    p_excl_a_r9: assert property (@(posedge a_raw_i) disable iff (!rst_n)
        $onehot0({a_en_q, b_en_q}));
    p_excl_b_r9: assert property (@(posedge b_raw_i) disable iff (!rst_n)
        $onehot0({a_en_q, b_en_q}));

endmodule

// File: rtl/dclk_clkout.sv
module dclk_clkout #(
    parameter int CNT_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] div_i,
    output logic       clk_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] en_sync;
        logic [CNT_W-1:0]       cnt;
    } cko_state_t;

    cko_state_t st_d, st_q;
    logic       raw_div, gate_q;

    always_comb begin
        case (div_i)
            2'd1:    raw_div = st_q.cnt[0];
            2'd2:    raw_div = st_q.cnt[1];
            2'd3:    raw_div = st_q.cnt[2];
            default: raw_div = 1'b0;
        endcase
        st_d         = st_q;
        st_d.en_sync = {st_q.en_sync[SYNC_STAGES-2:0], en_i};
        st_d.cnt     = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if ((div_i == 2'd0) || !raw_div) begin
            gate_q <= st_q.en_sync[SYNC_STAGES-1];
        end
    end

    assign clk_o = gate_q & ((div_i == 2'd0) ? clk_i : raw_div);

endmodule

// File: rtl/dual_clk_ctrl.sv
module dual_clk_ctrl
    import dclk_pkg::*;
#(
    parameter int FAST_WAIT_LONG = 128,
    parameter int SLOW_WAIT_LONG = 128,
    parameter int SYNC_STAGES    = 2,
    parameter int CKO_CNT_W      = 3
) (
    input  logic       fast_ref_i,
    input  logic       slow_ref_i,
    input  logic       rst_n,
    input  logic       fast_en_i,
    input  logic [1:0] fast_rate_i,
    input  logic [1:0] fast_wait_i,
    input  logic       slow_en_i,
    input  logic [1:0] slow_wait_i,
    input  logic       sleep_i,
    input  logic       sys_sel_slow_i,
    input  logic       cko_en_i,
    input  logic [1:0] cko_div_i,
    output logic       sys_clk_o,
    output logic       sys_on_slow_o,
    output logic       fast_rdy_o,
    output logic       slow_rdy_o,
    output logic       cko_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] slow_rdy_sync;
        logic                   sel_slow;
    } sel_state_t;

    sel_state_t sel_d, sel_q;
    logic       fast_raw, fast_clk, slow_raw, slow_clk;
    logic       fast_rdy, slow_rdy, slow_rdy_s, target_rdy;

    dclk_source #(
        .WAIT_LONG    (FAST_WAIT_LONG),
        .STOP_IN_SLEEP(1'b1),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_fast (
        .ref_clk  (fast_ref_i),
        .rst_n    (rst_n),
        .en_i     (fast_en_i),
        .sleep_i  (sleep_i),
        .rate_i   (fast_rate_i),
        .wait_i   (fast_wait_i),
        .raw_clk_o(fast_raw),
        .src_clk_o(fast_clk),
        .ready_o  (fast_rdy)
    );

    dclk_source #(
        .WAIT_LONG    (SLOW_WAIT_LONG),
        .STOP_IN_SLEEP(1'b0),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_slow (
        .ref_clk  (slow_ref_i),
        .rst_n    (rst_n),
        .en_i     (slow_en_i),
        .sleep_i  (sleep_i),
        .rate_i   (RATE_FULL),
        .wait_i   (slow_wait_i),
        .raw_clk_o(slow_raw),
        .src_clk_o(slow_clk),
        .ready_o  (slow_rdy)
    );

    always_comb begin
        slow_rdy_s          = sel_q.slow_rdy_sync[SYNC_STAGES-1];
        target_rdy          = sys_sel_slow_i ? slow_rdy_s : fast_rdy;
        sel_d               = sel_q;
        sel_d.slow_rdy_sync = {sel_q.slow_rdy_sync[SYNC_STAGES-2:0], slow_rdy};
        if ((sys_sel_slow_i != sel_q.sel_slow) && target_rdy) begin
            sel_d.sel_slow = sys_sel_slow_i;
        end
    end

    always_ff @(posedge fast_ref_i or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    dclk_glitchfree #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_switch (
        .rst_n  (rst_n),
        .a_raw_i(fast_raw),
        .a_clk_i(fast_clk),
        .b_raw_i(slow_raw),
        .b_clk_i(slow_clk),
        .sel_b_i(sel_q.sel_slow),
        .clk_o  (sys_clk_o)
    );

    dclk_clkout #(
        .CNT_W      (CKO_CNT_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_cko (
        .clk_i(sys_clk_o),
        .rst_n(rst_n),
        .en_i (cko_en_i),
        .div_i(cko_div_i),
        .clk_o(cko_o)
    );

    assign sys_on_slow_o = sel_q.sel_slow;
    assign fast_rdy_o    = fast_rdy;
    assign slow_rdy_o    = slow_rdy;

    // R8: the sub-clock cannot be taken while its synchronized ready is low.
    p_sel_guard_r8: assert property (@(posedge fast_ref_i) disable iff (!rst_n)
        (!sel_q.sel_slow && !slow_rdy_s) |=> !sel_q.sel_slow);

endmodule

// File: tb/dual_clk_ctrl_bench.sv
module dual_clk_ctrl_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic clk = 1'b0;
    logic slow_ref = 1'b0;
    always #2.5 clk = ~clk;
    always #15.5 slow_ref = ~slow_ref;

    logic       rst_n = 1'b0;
    logic       fast_en = 1'b1, slow_en = 1'b0, sleep = 1'b0, sel_slow = 1'b0;
    logic       cko_en = 1'b0;
    logic [1:0] fast_rate = 2'd0, fast_wait = 2'd0, slow_wait = 2'd0, cko_div = 2'd0;
    logic       sys_clk, on_slow, fast_rdy, slow_rdy, cko;

    dual_clk_ctrl u_dual_clk_ctrl (
        .fast_ref_i    (clk),
        .slow_ref_i    (slow_ref),
        .rst_n         (rst_n),
        .fast_en_i     (fast_en),
        .fast_rate_i   (fast_rate),
        .fast_wait_i   (fast_wait),
        .slow_en_i     (slow_en),
        .slow_wait_i   (slow_wait),
        .sleep_i       (sleep),
        .sys_sel_slow_i(sel_slow),
        .cko_en_i      (cko_en),
        .cko_div_i     (cko_div),
        .sys_clk_o     (sys_clk),
        .sys_on_slow_o (on_slow),
        .fast_rdy_o    (fast_rdy),
        .slow_rdy_o    (slow_rdy),
        .cko_o         (cko)
    );

    int      n_chk = 0, n_bad = 0;
    int      sys_edges = 0, cko_edges = 0, wd = 0;
    bit      done = 1'b0, track = 1'b0;
    realtime last_t = 0.0, min_w = 1.0e9;

    always @(posedge sys_clk) sys_edges++;
    always @(posedge cko) cko_edges++;
    always @(sys_clk) begin
        if (track && ($realtime - last_t < min_w)) min_w = $realtime - last_t;
        last_t = $realtime;
    end

    task automatic chk(input string req, input string what, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sys_count(input int n, output int got);
        int e0;
        e0 = sys_edges;
        cyc(n);
        got = sys_edges - e0;
    endtask

    task automatic fast_latency(output int n);
        n = 0;
        while (!fast_rdy && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        int n;
        cyc(4);
        chk("R1", "fast_rdy in reset", int'(fast_rdy), 0, 0);
        chk("R1", "slow_rdy in reset", int'(slow_rdy), 0, 0);
        chk("R1", "selection in reset", int'(on_slow), 0, 0);
        rst_n = 1'b1;
        sys_count(20, n);
        chk("R1", "sys edges before ready", n, 0, 0);
        chk("R1", "clock-out low", int'(cko), 0, 0);
        fast_latency(n);
        chk("R2", "reset wait code 0", n + 20, 128, 134);
        cyc(4);
        sys_count(64, n);
        chk("R3", "sys follows fast after reset", n, 62, 66);
    endtask

    task automatic t_wait_codes;
        int n;
        for (int w = 1; w < 4; w++) begin
            fast_en = 1'b0;
            cyc(8);
            chk("R4", "ready low when disabled", int'(fast_rdy), 0, 0);
            sys_count(16, n);
            chk("R4", "sys stopped when disabled", n, 0, 0);
            fast_wait = 2'(w);
            fast_en = 1'b1;
            fast_latency(n);
            chk("R2", $sformatf("wait code %0d", w), n, 128 >> w, (128 >> w) + 6);
        end
        fast_wait = 2'd0;
    endtask

    task automatic t_rates;
        int n;
        for (int r = 0; r < 4; r++) begin
            fast_rate = 2'(r);
            cyc(8);
            sys_count(128, n);
            chk("R6", $sformatf("rate code %0d", r), n,
                (r == 3 ? 128 : 128 >> r) - 2, (r == 3 ? 128 : 128 >> r) + 2);
        end
        fast_rate = 2'd0;
        cyc(8);
    endtask

    task automatic t_sleep_fast;
        int n;
        sleep = 1'b1;
        cyc(10);
        chk("R5", "fast ready in sleep", int'(fast_rdy), 0, 0);
        sys_count(32, n);
        chk("R5", "sys stopped in sleep", n, 0, 0);
        sleep = 1'b0;
        fast_latency(n);
        chk("R5", "full wait after sleep", n, 128, 134);
    endtask

    task automatic t_reject;
        int n;
        sel_slow = 1'b1;
        cyc(20);
        chk("R8", "selection unchanged", int'(on_slow), 0, 0);
        sys_count(64, n);
        chk("R8", "sys still fast", n, 62, 66);
        sel_slow = 1'b0;
        cyc(4);
    endtask

    task automatic t_switch;
        int n;
        slow_wait = 2'd3;
        slow_en = 1'b1;
        n = 0;
        while (!slow_rdy && n < 500) begin
            @(negedge slow_ref);
            n++;
        end
        chk("R7", "slow wait code 3", n, 16, 22);
        @(negedge clk);
        min_w = 1.0e9;
        track = 1'b1;
        sel_slow = 1'b1;
        cyc(40);
        chk("R9", "selection moved", int'(on_slow), 1, 1);
        sys_count(62, n);
        chk("R9", "sys follows slow", n, 9, 11);
        sleep = 1'b1;
        cyc(10);
        chk("R5", "fast stops in sleep", int'(fast_rdy), 0, 0);
        chk("R7", "slow ready through sleep", int'(slow_rdy), 1, 1);
        sys_count(62, n);
        chk("R7", "slow runs in sleep", n, 9, 11);
        sleep = 1'b0;
        fast_latency(n);
        chk("R5", "fast wait after sleep", n, 128, 134);
        sel_slow = 1'b0;
        cyc(40);
        chk("R9", "selection back", int'(on_slow), 0, 0);
        sys_count(64, n);
        chk("R9", "sys follows fast", n, 62, 66);
        track = 1'b0;
        chk("R9", "min pulse x10ns", int'(min_w * 10.0), 24, 1000000);
    endtask

    task automatic t_clkout;
        int e0, n;
        cko_en = 1'b1;
        for (int d = 0; d < 4; d++) begin
            cko_div = 2'(d);
            cyc(16);
            e0 = cko_edges;
            cyc(128);
            n = cko_edges - e0;
            chk("R10", $sformatf("divide code %0d", d), n, (128 >> d) - 2, (128 >> d) + 2);
        end
        cko_en = 1'b0;
        cyc(16);
        e0 = cko_edges;
        cyc(32);
        chk("R11", "clock-out quiet", cko_edges - e0, 0, 0);
        chk("R11", "clock-out low", int'(cko), 0, 0);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_wait_codes();
        t_rates();
        t_sleep_fast();
        t_reject();
        t_switch();
        t_clkout();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule